// File: doc/BRIEF.md
# Instruction Length and Conditional Skip Unit

This unit sits between instruction fetch and execute in a 16-bit processor. It takes the first word of an instruction together with the address of that word. From the word it splits out the operation code and the two operand selectors. It then works out whether each operand needs an extra word that follows the instruction in memory. From that it gives the total instruction length, the addresses of the extra words and the address of the next instruction.

The unit also holds the skip state for conditional instructions. Execute reports a failed test on `cond_fail` while a conditional is presented. The instruction that follows is then consumed without being executed. A conditional that is itself skipped keeps the skip active, so a chain of conditionals drops out as a group. For each instruction the unit reports whether execute may act on it and how many cycles the conditional and skip handling adds.

Top module: `ilsk_unit`

## Requirements
- R1: The instruction word `{a[5:0], b[4:0], op[4:0]}` is split with `op` in bits 4:0, `b` in bits 9:5 and `a` in bits 15:10.
- R2: Operand b needs an extra word only when `op` is nonzero and `b` is 0x10 to 0x17, 0x1E or 0x1F.
- R3: Operand a needs an extra word only when `a` is 0x10 to 0x17, 0x1E or 0x1F and at least one of `op` and `b` is nonzero. Codes 0x20 and above never need one.
- R4: `instr_len` is 1 plus the number of extra words. `next_pc` is `instr_addr + instr_len` modulo 2^16.
- R5: The extra word for b is at `instr_addr + 1`. The extra word for a comes after it, at `instr_addr + 1 + (b needs a word)`. Both wrap modulo 2^16.
- R6: A conditional instruction has `op` 0x10 to 0x17. When executed it charges 2 cycles, or 3 when `cond_fail` is high. An executed non-conditional charges 0.
- R7: An executed conditional with `cond_fail` high makes the next valid instruction skipped. `cond_fail` on an executed non-conditional has no effect on skipping.
- R8: A skipped instruction has `exec_en` low and still reports its full decoded length and `next_pc`.
- R9: A skipped conditional keeps skipping for the next valid instruction and charges 1 cycle, whatever the value of `cond_fail`.
- R10: A skipped non-conditional ends skipping and charges 0 cycles.
- R11: Reset clears the skip state, so the first valid instruction after reset has `exec_en` high.
- R12: Cycles with `instr_valid` low leave the skip state unchanged and give `exec_en` low and a charge of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction word is presented this cycle |
| instr_word | input | 16 | First word of the instruction |
| instr_addr | input | 16 | Address of the first word |
| cond_fail | input | 1 | The test of the conditional presented this cycle failed |
| op_code | output | 5 | Operation field |
| b_code | output | 5 | Operand b selector |
| a_code | output | 6 | Operand a selector |
| b_ext_need | output | 1 | Operand b takes an extra word |
| a_ext_need | output | 1 | Operand a takes an extra word |
| b_ext_addr | output | 16 | Address of the b extra word |
| a_ext_addr | output | 16 | Address of the a extra word |
| instr_len | output | 2 | Instruction length in words (1 to 3) |
| next_pc | output | 16 | Address of the following instruction |
| exec_en | output | 1 | Execute may act on this instruction |
| cycle_charge | output | 2 | Cycles added by conditional and skip handling |

## Verification
A failed-test report and the skip state can meet in the same cycle, and this is where the two functions collide. It happens when a skipped conditional arrives with `cond_fail` high, or a skipped non-conditional arrives with it high. The bench drives such instructions in chains and with idle cycles between them. It judges each one by `exec_en`, by the charge, and by whether the instruction after it is executed. The scoreboard expects `cond_fail` to be ignored while skipping: a chain of skipped conditionals charges 1 cycle each and ends only at the first skipped non-conditional.

// File: rtl/ilsk_pkg.sv
package ilsk_pkg;
  localparam int WORD_W = 16;
  localparam int OP_W   = 5;
  localparam int BF_W   = 5;
  localparam int AF_W   = 6;
  localparam int LEN_W  = 2;
  localparam int CHG_W  = 2;

  localparam logic [OP_W-1:0] COND_FIRST = 5'h10;
  localparam logic [OP_W-1:0] COND_LAST  = 5'h17;

  // selector codes that pull a following word: 0x10..0x17, 0x1E, 0x1F
  function automatic logic sel_takes_word(input logic [AF_W-1:0] sel);
    return ((sel >= 6'h10) && (sel <= 6'h17)) || (sel == 6'h1E) || (sel == 6'h1F);
  endfunction

  function automatic logic op_is_cond(input logic [OP_W-1:0] op);
    return (op >= COND_FIRST) && (op <= COND_LAST);
  endfunction
endpackage

// File: rtl/ilsk_field_decode.sv
module ilsk_field_decode
  import ilsk_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [OP_W-1:0]   op_o,
  output logic [BF_W-1:0]   b_o,
  output logic [AF_W-1:0]   a_o,
  output logic              b_need_o,
  output logic              a_need_o,
  output logic              cond_o
);
  localparam int B_LSB = OP_W;
  localparam int A_LSB = OP_W + BF_W;

  always_comb begin
    op_o     = word_i[B_LSB-1:0];
    b_o      = word_i[A_LSB-1:B_LSB];
    a_o      = word_i[WORD_W-1:A_LSB];
    // b only pulls a word for two-operand forms
    b_need_o = (op_o != '0) && sel_takes_word({1'b0, b_o});
    // a pulls a word unless the whole low part of the word is zero
    a_need_o = ((op_o != '0) || (b_o != '0)) && sel_takes_word(a_o);
    cond_o   = op_is_cond(op_o);
  end
endmodule

// File: rtl/ilsk_addr_gen.sv
module ilsk_addr_gen
  import ilsk_pkg::*;
(
  input  logic [WORD_W-1:0] addr_i,
  input  logic              b_need_i,
  input  logic              a_need_i,
  output logic [LEN_W-1:0]  len_o,
  output logic [WORD_W-1:0] b_addr_o,
  output logic [WORD_W-1:0] a_addr_o,
  output logic [WORD_W-1:0] next_o
);
  always_comb begin
    len_o    = LEN_W'(1) + LEN_W'(b_need_i) + LEN_W'(a_need_i);
    b_addr_o = addr_i + WORD_W'(1);
    a_addr_o = addr_i + WORD_W'(1) + WORD_W'(b_need_i);
    next_o   = addr_i + WORD_W'(len_o);
  end
endmodule

// File: rtl/ilsk_skip_ctrl.sv
module ilsk_skip_ctrl
  import ilsk_pkg::*;
#(
  parameter logic [CHG_W-1:0] COND_COST      = 2'd2,
  parameter logic [CHG_W-1:0] FAIL_COST      = 2'd1,
  parameter logic [CHG_W-1:0] SKIP_COND_COST = 2'd1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             cond_i,
  input  logic             fail_i,
  output logic             skip_o,
  output logic             exec_o,
  output logic [CHG_W-1:0] charge_o
);
  logic skip_q, skip_d, skip_en;

  always_comb begin
    skip_d   = skip_q;
    exec_o   = 1'b0;
    charge_o = '0;
    skip_en  = valid_i;
    if (valid_i) begin
      if (skip_q) begin
        skip_d = cond_i;
        if (cond_i) charge_o = SKIP_COND_COST;
      end else begin
        exec_o = 1'b1;
        skip_d = cond_i && fail_i;
        if (cond_i) charge_o = COND_COST + (fail_i ? FAIL_COST : '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       skip_q <= 1'b0;
    else if (skip_en) skip_q <= skip_d;
  end

  assign skip_o = skip_q;

  a_r7_fail_sets_skip: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !skip_q && cond_i && fail_i |=> skip_q);
  a_r9_chain_holds: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && skip_q && cond_i |=> skip_q);
  a_r10_skip_ends: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && skip_q && !cond_i |=> !skip_q);
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(skip_q));
  a_r7_noncond_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !skip_q && !cond_i |=> !skip_q);
endmodule

// File: rtl/ilsk_unit.sv
module ilsk_unit
  import ilsk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_valid,
  input  logic [15:0] instr_word,
  input  logic [15:0] instr_addr,
  input  logic        cond_fail,
  output logic [4:0]  op_code,
  output logic [4:0]  b_code,
  output logic [5:0]  a_code,
  output logic        b_ext_need,
  output logic        a_ext_need,
  output logic [15:0] b_ext_addr,
  output logic [15:0] a_ext_addr,
  output logic [1:0]  instr_len,
  output logic [15:0] next_pc,
  output logic        exec_en,
  output logic [1:0]  cycle_charge
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       is_cond;
  logic       skip_state;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ilsk_field_decode u_dec (
    .word_i   (instr_word),
    .op_o     (op_code),
    .b_o      (b_code),
    .a_o      (a_code),
    .b_need_o (b_ext_need),
    .a_need_o (a_ext_need),
    .cond_o   (is_cond)
  );

  ilsk_addr_gen u_addr (
    .addr_i   (instr_addr),
    .b_need_i (b_ext_need),
    .a_need_i (a_ext_need),
    .len_o    (instr_len),
    .b_addr_o (b_ext_addr),
    .a_addr_o (a_ext_addr),
    .next_o   (next_pc)
  );

  ilsk_skip_ctrl u_skip (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .valid_i  (instr_valid),
    .cond_i   (is_cond),
    .fail_i   (cond_fail),
    .skip_o   (skip_state),
    .exec_o   (exec_en),
    .charge_o (cycle_charge)
  );

  a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_int_n)
    instr_valid |-> (instr_len != 2'd0));
  a_r5_a_after_b: assert property (@(posedge clk) disable iff (!rst_int_n)
    instr_valid && b_ext_need |-> (a_ext_addr == b_ext_addr + 16'd1));
  a_r8_skip_no_exec: assert property (@(posedge clk) disable iff (!rst_int_n)
    skip_state |-> !exec_en);
endmodule

// File: tb/sim_ilsk_unit.sv
`timescale 1ns/100ps
module sim_ilsk_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [15:0] instr_word, instr_addr;
  logic        cond_fail;
  logic [4:0]  op_code, b_code;
  logic [5:0]  a_code;
  logic        b_ext_need, a_ext_need, exec_en;
  logic [15:0] b_ext_addr, a_ext_addr, next_pc;
  logic [1:0]  instr_len, cycle_charge;

  always #2.5 clk = ~clk;

  ilsk_unit u0 (.*);

  typedef struct {
    logic        valid;
    logic [4:0]  op, b;
    logic [5:0]  a;
    logic        bn, an;
    logic [15:0] ba, aa, np;
    logic [1:0]  len, chg;
    logic        ex;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   errors = 0, checks = 0;
  logic model_skip = 1'b0;
  logic done = 1'b0;

  function automatic logic takes(input logic [5:0] s);
    return (s >= 6'h10 && s <= 6'h17) || s == 6'h1E || s == 6'h1F;
  endfunction

  function automatic logic [15:0] mk(input logic [5:0] a, input logic [4:0] b, input logic [4:0] op);
    return {a, b, op};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] w, input logic [15:0] ad,
                       input logic f, input string tag);
    exp_t e;
    logic cond;
    @(negedge clk);
    instr_valid = v; instr_word = w; instr_addr = ad; cond_fail = f;
    e.valid = v; e.tag = tag;
    e.op = w[4:0]; e.b = w[9:5]; e.a = w[15:10];
    e.bn = (e.op != 0) && takes({1'b0, e.b});
    e.an = ((e.op != 0) || (e.b != 0)) && takes(e.a);
    e.len = 2'd1 + 2'(e.bn) + 2'(e.an);
    e.np = ad + 16'(e.len);
    e.ba = ad + 16'd1;
    e.aa = ad + 16'd1 + 16'(e.bn);
    cond = (e.op >= 5'h10) && (e.op <= 5'h17);
    if (!v) begin
      e.ex = 0; e.chg = 0;
    end else if (model_skip) begin
      e.ex = 0; e.chg = cond ? 2'd1 : 2'd0; model_skip = cond;
    end else begin
      e.ex = 1; e.chg = cond ? (2'd2 + 2'(f)) : 2'd0; model_skip = cond && f;
    end
    q.push_back(e);
  endtask

  // monitor: compare in the low phase, after the driver has applied inputs
  initial begin
    forever begin
      @(negedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.valid) begin
          chk({op_code, b_code, a_code} == {e.op, e.b, e.a}, "R1 fields",
              {op_code, b_code, a_code}, {e.op, e.b, e.a});
          chk(b_ext_need == e.bn, "R2 b extra word", b_ext_need, e.bn);
          chk(a_ext_need == e.an, "R3 a extra word", a_ext_need, e.an);
          chk(instr_len == e.len && next_pc == e.np, "R4 length/next_pc",
              {instr_len, next_pc}, {e.len, e.np});
          if (e.bn) chk(b_ext_addr == e.ba, "R5 b word address", b_ext_addr, e.ba);
          if (e.an) chk(a_ext_addr == e.aa, "R5 a word address", a_ext_addr, e.aa);
        end
        chk(exec_en == e.ex, {e.tag, " exec_en"}, exec_en, e.ex);
        chk(cycle_charge == e.chg, {e.tag, " charge"}, cycle_charge, e.chg);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; instr_valid = 1'b0; cond_fail = 1'b0;
    instr_word = '0; instr_addr = '0;
    model_skip = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0; instr_addr = '0; cond_fail = 1'b0;
    do_reset();
    // R11/R12 reset state: idle gives no exec, no charge
    #1 chk(exec_en == 1'b0 && cycle_charge == 2'd0, "R11 reset idle", {exec_en, cycle_charge}, 0);
    // R11 first instruction executes; R2 R3 R4 three-word form
    drive(1, mk(6'h1E, 5'h10, 5'h01), 16'h0100, 0, "R11");
    drive(1, mk(6'h00, 5'h00, 5'h02), 16'h0103, 0, "R6 plain");
    drive(1, mk(6'h1F, 5'h10, 5'h00), 16'h0104, 0, "R3 special");
    drive(1, mk(6'h10, 5'h00, 5'h00), 16'h0106, 0, "R3 all-zero");
    drive(1, mk(6'h20, 5'h1F, 5'h03), 16'h0107, 0, "R3 high code");
    drive(1, mk(6'h17, 5'h18, 5'h04), 16'h0109, 0, "R2 b 0x18");
    drive(1, mk(6'h00, 5'h1D, 5'h04), 16'h010A, 0, "R2 b 0x1D");
    drive(1, mk(6'h16, 5'h17, 5'h05), 16'h010B, 0, "R5");
    // R4 R5 wrap at top of memory
    drive(1, mk(6'h11, 5'h1F, 5'h01), 16'hFFFE, 0, "R5 wrap");
    // R6 passing conditional, then R7 non-conditional with fail high
    drive(1, mk(6'h00, 5'h01, 5'h12), 16'h0200, 0, "R6 cond pass");
    drive(1, mk(6'h00, 5'h01, 5'h01), 16'h0201, 1, "R7 noncond fail");
    drive(1, mk(6'h00, 5'h01, 5'h01), 16'h0202, 0, "R7 still executing");
    // R6 failing conditional, R8 skipped three-word instr with fail high, R10
    drive(1, mk(6'h00, 5'h01, 5'h10), 16'h0300, 1, "R6 cond fail");
    drive(1, mk(6'h1E, 5'h10, 5'h01), 16'h0301, 1, "R8 skipped");
    drive(1, mk(6'h00, 5'h01, 5'h01), 16'h0304, 0, "R10 after skip");
    // R9 chain: fail, skipped cond (fail high), skipped cond (fail low), skipped plain
    drive(1, mk(6'h00, 5'h02, 5'h13), 16'h0400, 1, "R6 chain head");
    drive(1, mk(6'h10, 5'h02, 5'h17), 16'h0401, 1, "R9 skipped cond fail");
    drive(1, mk(6'h00, 5'h02, 5'h10), 16'h0403, 0, "R9 skipped cond");
    drive(1, mk(6'h00, 5'h02, 5'h02), 16'h0404, 1, "R10 end chain");
    drive(1, mk(6'h00, 5'h02, 5'h02), 16'h0405, 0, "R10 resumed");
    // R12 idle cycles hold the skip state
    drive(1, mk(6'h00, 5'h02, 5'h14), 16'h0500, 1, "R6 fail before idle");
    drive(0, mk(6'h00, 5'h02, 5'h01), 16'h0000, 1, "R12 idle");
    drive(0, 16'h0000, 16'h0000, 0, "R12 idle");
    drive(1, mk(6'h00, 5'h02, 5'h01), 16'h0501, 0, "R12 skipped after idle");
    drive(1, mk(6'h00, 5'h02, 5'h01), 16'h0502, 0, "R12 resumed");
    // R11 reset while skipping
    drive(1, mk(6'h00, 5'h02, 5'h15), 16'h0600, 1, "R6 fail before reset");
    @(negedge clk);
    do_reset();
    drive(1, mk(6'h00, 5'h02, 5'h01), 16'h0601, 0, "R11 after reset");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=0x1 expected=0x0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule